// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block turns a fast system clock into the two timing strobes a serial port needs. An optional divide-by-8 prescaler comes first. A sample divisor then counts prescaled clock enables and emits a one-cycle sample strobe for the receiver's oversampling logic. A bit divisor counts those sample strobes and emits a one-cycle bit strobe for the transmitter. The resulting bit rate is the selected clock divided by `cd * (bdiv + 1)`, where the selected clock is the system clock or one eighth of it.

The sample divisor, the bit divisor and the prescaler select are captured together on a single-cycle configuration write. Every write restarts all three counters from zero, so the first period after a change is always a full, correct period. A sample divisor of 0 or 1 parks the generator, and it emits no strobes.

Top module: `rate_gen`

## Requirements
- R1: While reset is asserted and after it is released with no configuration written, both `sample_tick_o` and `bit_tick_o` stay low, because the held sample divisor resets to 0.
- R2: With `pre_div_sel_i` captured as 0 and a sample divisor `cd` of 2 or more, `sample_tick_o` is a one-cycle pulse repeating every `cd` clock cycles.
- R3: With `pre_div_sel_i` captured as 1, the sample strobe repeats every `8 * cd` clock cycles.
- R4: `bit_tick_o` pulses only together with `sample_tick_o`, once every `bdiv + 1` sample strobes; `bdiv = 0` gives a bit strobe on every sample strobe.
- R5: A captured sample divisor of 0 or 1 produces no sample strobes and no bit strobes.
- R6: A cycle with `cfg_wr_i` high loads `cd_i`, `bdiv_i` and `pre_div_sel_i` at that clock edge and restarts all counters. Cycles after that edge are numbered from 0. The first sample strobe is in cycle `S - 1` and the first bit strobe is in cycle `S * (bdiv + 1) - 1`, where `S` is `cd` or `8 * cd`. This holds even when the write lands partway through a period.
- R7: Changes on `cd_i`, `bdiv_i` or `pre_div_sel_i` while `cfg_wr_i` is low have no effect on the strobe timing.
- R8: The full 16-bit sample divisor range works; `cd = 65535` gives its first sample strobe in cycle 65534 after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe; loads the three settings and restarts the counters |
| pre_div_sel_i | input | 1 | 1 selects the clock divided by 8, 0 the undivided clock |
| cd_i | input | 16 | Sample divisor (clock enables per sample strobe); 0 and 1 disable |
| bdiv_i | input | 8 | Bit divisor; sample strobes per bit equal this value plus one |
| sample_tick_o | output | 1 | One-cycle strobe per receive sample |
| bit_tick_o | output | 1 | One-cycle strobe per transmitted bit |

## Verification
The bench builds the block with its default parameters: a 16-bit sample divisor, an 8-bit bit divisor and a prescale ratio of 8. With these values the top of the sample-divisor range (65535) can be tested directly, and the prescaled path stretches periods by a factor of 8. The bench measures the cycle index of the first sample strobe, the first bit strobe and the second bit strobe after each write, and the number of sample strobes between the bit strobes. It covers the disabled divisor values, a write in the middle of a period, and input changes made without a write.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int unsigned CD_MIN = 2;  // smallest sample divisor that runs

  typedef enum logic {
    PRE_DIRECT = 1'b0,
    PRE_DIVIDED = 1'b1
  } pre_sel_e;
endpackage

// File: rtl/rate_gen_prescale.sv
module rate_gen_prescale #(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  rate_gen_pkg::pre_sel_e sel_i,
  output logic en_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || sel_i == rate_gen_pkg::PRE_DIRECT) cnt_q <= '0;
    else if (cnt_q == PRE_LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = (sel_i == rate_gen_pkg::PRE_DIRECT) || (cnt_q == PRE_LAST);
endmodule

// File: rtl/rate_gen_sample_div.sv
module rate_gen_sample_div #(
  parameter int unsigned CD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [CD_W-1:0] cd_i,
  output logic            tick_o
);
  localparam logic [CD_W-1:0] MIN_CD = CD_W'(rate_gen_pkg::CD_MIN);

  logic [CD_W-1:0] cnt_q;
  logic            run;
  logic            last;

  assign run  = (cd_i >= MIN_CD);
  assign last = (cnt_q == cd_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || !run) cnt_q <= '0;
    else if (en_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run && en_i && last;
endmodule

// File: rtl/rate_gen_bit_div.sv
module rate_gen_bit_div #(
  parameter int unsigned BDIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic              bit_o
);
  logic [BDIV_W-1:0] cnt_q;
  logic              last;

  assign last = (cnt_q == bdiv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign bit_o = tick_i && last;
endmodule

// File: rtl/rate_gen.sv
module rate_gen #(
  parameter int unsigned CD_W    = 16,
  parameter int unsigned BDIV_W  = 8,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              pre_div_sel_i,
  input  logic [CD_W-1:0]   cd_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  import rate_gen_pkg::*;

  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;
  pre_sel_e          sel_q;
  logic              pre_en;

  // settings and counter restart share the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_q   <= '0;
      bdiv_q <= '0;
      sel_q  <= PRE_DIRECT;
    end else if (cfg_wr_i) begin
      cd_q   <= cd_i;
      bdiv_q <= bdiv_i;
      sel_q  <= pre_sel_e'(pre_div_sel_i);
    end
  end

  rate_gen_prescale #(.PRE_DIV(PRE_DIV)) u_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_wr_i),
    .sel_i (sel_q),
    .en_o  (pre_en)
  );

  rate_gen_sample_div #(.CD_W(CD_W)) u_sample_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_wr_i),
    .en_i  (pre_en),
    .cd_i  (cd_q),
    .tick_o(sample_tick_o)
  );

  rate_gen_bit_div #(.BDIV_W(BDIV_W)) u_bit_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_wr_i),
    .tick_i(sample_tick_o),
    .bdiv_i(bdiv_q),
    .bit_o (bit_tick_o)
  );
endmodule

// File: rtl/rate_gen_checker.sv
module rate_gen_checker #(
  parameter int unsigned CD_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_wr_i,
  input logic [CD_W-1:0] cd_q_i,
  input logic            pre_en_i,
  input logic            sample_tick_i,
  input logic            bit_tick_i
);
  a_r4_bit_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_i |-> sample_tick_i);

  a_r5_parked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_q_i < CD_W'(2)) |-> (!sample_tick_i && !bit_tick_i));

  a_r6_restart_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !sample_tick_i);

  a_r2_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_i |=> !sample_tick_i);

  a_r3_tick_needs_prescale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_i |-> pre_en_i);
endmodule

bind rate_gen rate_gen_checker #(.CD_W(CD_W)) u_rate_gen_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_wr_i     (cfg_wr_i),
  .cd_q_i       (cd_q),
  .pre_en_i     (pre_en),
  .sample_tick_i(sample_tick_o),
  .bit_tick_i   (bit_tick_o)
);

// File: tb/rate_gen_test.sv
`timescale 1ns/1ps
module rate_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        pre_div_sel_i = 1'b0;
  logic [15:0] cd_i = '0;
  logic [7:0]  bdiv_i = '0;
  logic        sample_tick_o;
  logic        bit_tick_o;

  int checks = 0;
  int errors = 0;
  int fs, fb, sb, ns, nb, ns_at_fb, between;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rate_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i),
    .pre_div_sel_i(pre_div_sel_i), .cd_i(cd_i), .bdiv_i(bdiv_i),
    .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o)
  );

  // sel, cd, bdiv, sample period S, bit period B
  localparam int V_N = 5;
  localparam int v_sel[V_N] = '{0, 0, 1, 0, 1};
  localparam int v_cd [V_N] = '{2, 3, 5, 300, 2};
  localparam int v_bd [V_N] = '{0, 4, 1, 2, 0};
  localparam int v_s  [V_N] = '{2, 3, 40, 300, 16};
  localparam int v_b  [V_N] = '{2, 15, 80, 900, 16};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write settings; returns at the negedge of cycle 0 after the load edge
  task automatic write_cfg(input int sel, input int cd, input int bd);
    @(negedge clk_i);
    cfg_wr_i = 1'b1;
    pre_div_sel_i = sel[0];
    cd_i = cd[15:0];
    bdiv_i = bd[7:0];
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic observe(input int ncyc);
    fs = -1; fb = -1; sb = -1; ns = 0; nb = 0; ns_at_fb = 0; between = -1;
    for (int j = 0; j < ncyc; j++) begin
      if (j > 0) @(negedge clk_i);
      if (sample_tick_o) begin
        ns++;
        if (fs < 0) fs = j;
      end
      if (bit_tick_o) begin
        nb++;
        if (fb < 0) begin
          fb = j;
          ns_at_fb = ns;
        end else if (sb < 0) begin
          sb = j;
          between = ns - ns_at_fb;
        end
      end
    end
  endtask

  initial begin
    #(190000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 sample low in reset", int'(sample_tick_o), 0);
    chk("R1 bit low in reset", int'(bit_tick_o), 0);
    rst_ni = 1'b1;
    observe(50);
    chk("R1 no samples before write", ns, 0);
    chk("R1 no bits before write", nb, 0);

    // table walk: R2/R3 sample timing, R4 bit timing, R6 first strobes
    for (int i = 0; i < V_N; i++) begin
      write_cfg(v_sel[i], v_cd[i], v_bd[i]);
      observe(2 * v_b[i] + 4);
      chk(v_sel[i] != 0 ? "R3 first sample" : "R2 first sample", fs, v_s[i] - 1);
      chk("R6 first bit", fb, v_b[i] - 1);
      chk("R4 second bit", sb, 2 * v_b[i] - 1);
      chk("R4 samples per bit", between, v_bd[i] + 1);
      chk(v_sel[i] != 0 ? "R3 sample count" : "R2 sample count", ns,
          (2 * v_b[i] + 4) / v_s[i]);
    end

    // R5: disabled divisor values
    write_cfg(0, 0, 0);
    observe(100);
    chk("R5 cd0 samples", ns, 0);
    chk("R5 cd0 bits", nb, 0);
    write_cfg(1, 1, 3);
    observe(100);
    chk("R5 cd1 samples", ns, 0);
    chk("R5 cd1 bits", nb, 0);

    // R6: write partway through a period restarts cleanly
    write_cfg(0, 10, 1);
    observe(7);
    chk("R6 no tick before rewrite", ns, 0);
    write_cfg(0, 4, 2);
    observe(30);
    chk("R6 restart first sample", fs, 3);
    chk("R6 restart first bit", fb, 11);
    chk("R6 restart second bit", sb, 23);

    // R7: inputs ignored without a write
    write_cfg(0, 6, 0);
    cd_i = 16'd2;
    bdiv_i = 8'd5;
    pre_div_sel_i = 1'b1;
    observe(30);
    chk("R7 first sample unchanged", fs, 5);
    chk("R7 sample count unchanged", ns, 5);
    chk("R7 bit count unchanged", nb, 5);

    // R8: top of the divisor range
    write_cfg(0, 65535, 0);
    observe(65540);
    chk("R8 first sample", fs, 65534);
    chk("R8 first bit", fb, 65534);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule